// File: doc/BRIEF.md
# Watermark Buffer Status Controller

This block keeps track of how full two circular sample buffers of a filter accelerator are. The host fills the input ring and drains the output ring. The accelerator supplies its own side of each ring: the index of the oldest input sample it still needs, and the index it will write its next result to. From these pointers and the host's pointers, the block works out the free input space and the unread output data. It compares each count against a programmable watermark and presents the outcome as a full flag and an empty flag. Both flags come out through a fixed three-cycle pipeline.

The block also decides whether each host access is allowed. A write into a ring with no free slot is dropped and latches a sticky overflow flag. A read from a ring with nothing unread is dropped and latches a sticky underflow flag. The dropped read returns zero in the datapath, which sees `rdAccept` low. A saturation pulse from the accumulator latches a sticky saturation flag. Only unit reset clears the sticky flags. A single interrupt line and two DMA request lines are formed from the flags and their enable bits.

All pointers carry one wrap bit above the ring index, so both rings must be a power of two deep. The accelerator pointers use the same encoding.

Top module: `wmbuf_status`

## Requirements
- R1: After reset, both host pointers are 0, `inFull`=0, `outEmpty`=1, all three sticky flags are 0, and with every enable at 0, `irq`, `dmaWrReq` and `dmaRdReq` are 0.
- R2: Free input space is IN_DEPTH − ((wrPtr − inTail) mod 2·IN_DEPTH). Unread output data is (outHead − rdPtr) mod 2·OUT_DEPTH. Pointers are log2(depth)+1 bits wide.
- R3: The full flag reflects free space < threshold. The 2-bit `fullWm` code maps 0,1,2,3 to thresholds 1,2,4,8.
- R4: The empty flag reflects unread data < threshold. `emptyWm` uses the same code as `fullWm`: 0,1,2,3 select thresholds 1,2,4,8.
- R5: `inFull` and `outEmpty` follow their condition with a latency of exactly three clock edges. After an access is sampled at edge k, the flag holds its old value through edge k+2 and shows the new value after edge k+3.
- R6: A host write while free space is 0 gives `wrAccept`=0 in that cycle and leaves `wrPtr` unchanged. It sets `ovflFlag`, which then stays 1 until reset.
- R7: A host read while unread data is 0 gives `rdAccept`=0 in that cycle and leaves `rdPtr` unchanged. It sets `unflFlag`, which then stays 1 until reset.
- R8: A `satEvent` pulse sets `satFlag` at the next edge, and it stays 1 until reset.
- R9: `dmaWrReq` = `wrDmaEn` & !`inFull`, and `dmaRdReq` = `rdDmaEn` & !`outEmpty`.
- R10: `irq` is 1 when any of these holds: `wrIntEn` with !`inFull`; `rdIntEn` with !`outEmpty`; or a sticky flag together with its own enable (`ovflIntEn`, `unflIntEn`, `satIntEn`).
- R11: An accepted write or read advances its pointer by 1 modulo 2·depth at the edge it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low unit reset |
| hostWr | input | 1 | Host write strobe into the input ring |
| hostRd | input | 1 | Host read strobe from the output ring |
| inTail | input | log2(IN_DEPTH)+1 | Oldest input sample still used by the filter |
| outHead | input | log2(OUT_DEPTH)+1 | Current output destination of the accelerator |
| fullWm | input | 2 | Full watermark code |
| emptyWm | input | 2 | Empty watermark code |
| wrIntEn | input | 1 | Interrupt while input not full |
| rdIntEn | input | 1 | Interrupt while output not empty |
| wrDmaEn | input | 1 | DMA write requests while input not full |
| rdDmaEn | input | 1 | DMA read requests while output not empty |
| ovflIntEn | input | 1 | Interrupt on overflow flag |
| unflIntEn | input | 1 | Interrupt on underflow flag |
| satIntEn | input | 1 | Interrupt on saturation flag |
| satEvent | input | 1 | Accumulator saturation pulse |
| wrAccept | output | 1 | Current write is taken |
| rdAccept | output | 1 | Current read is taken (else data reads as zero) |
| wrPtr | output | log2(IN_DEPTH)+1 | Host write pointer |
| rdPtr | output | log2(OUT_DEPTH)+1 | Host read pointer |
| inFull | output | 1 | Input ring below full watermark |
| outEmpty | output | 1 | Output ring below empty watermark |
| ovflFlag | output | 1 | Sticky overflow |
| unflFlag | output | 1 | Sticky underflow |
| satFlag | output | 1 | Sticky saturation |
| irq | output | 1 | Combined interrupt |
| dmaWrReq | output | 1 | DMA write request |
| dmaRdReq | output | 1 | DMA read request |

## Verification
The latency property rebuilds the free count from the ports three edges back. It therefore assumes that the accelerator pointers never move more than one ring depth away from the host pointers. It also assumes they hold their reset value of zero while reset is low. The bench moves `inTail` and `outHead` only in steps that keep these distances inside the ring. It never lets the accelerator overrun the host read pointer. Watermark codes change only while the bench is idle, and the bench waits four cycles before it samples a flag.

// File: rtl/wmbuf_status_pkg.sv
package wmbuf_status_pkg;

  // Advance strobes from control to datapath
  typedef struct packed {
    logic wrAdv;
    logic rdAdv;
  } advStrobe_t;

  // Watermark code to entry threshold: 1, 2, 4 or 8
  function automatic logic [3:0] wmThreshold(input logic [1:0] code);
    return 4'b0001 << code;
  endfunction

endpackage

// File: rtl/wmbuf_flag_pipe.sv
module wmbuf_flag_pipe #(
  parameter int   LAT     = 3,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [LAT-1:0] stage;

  generate
    if (LAT == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= RST_VAL;
        else       stage <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= {LAT{RST_VAL}};
        else       stage <= {stage[LAT-2:0], d};
      end
    end
  endgenerate

  assign q = stage[LAT-1];
endmodule

// File: rtl/wmbuf_status_dp.sv
module wmbuf_status_dp
  import wmbuf_status_pkg::*;
#(
  parameter int  IN_DEPTH  = 16,
  parameter int  OUT_DEPTH = 16,
  parameter int  FLAG_LAT  = 3,
  localparam int IPW = $clog2(IN_DEPTH) + 1,
  localparam int OPW = $clog2(OUT_DEPTH) + 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  advStrobe_t     strb,
  input  logic [IPW-1:0] inTail,
  input  logic [OPW-1:0] outHead,
  input  logic [1:0]     fullWm,
  input  logic [1:0]     emptyWm,
  output logic [IPW-1:0] wrPtr,
  output logic [OPW-1:0] rdPtr,
  output logic           noSpace,
  output logic           noData,
  output logic           inFull,
  output logic           outEmpty
);
  logic [IPW-1:0] usedCnt, freeCnt;
  logic [OPW-1:0] unreadCnt;
  logic           rawFull, rawEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.wrAdv) wrPtr <= wrPtr + 1'b1;
      if (strb.rdAdv) rdPtr <= rdPtr + 1'b1;
    end
  end

  // Distances modulo twice the depth, wrap bit included
  always_comb begin
    usedCnt   = wrPtr - inTail;
    freeCnt   = IPW'(IN_DEPTH) - usedCnt;
    unreadCnt = outHead - rdPtr;
    noSpace   = (freeCnt == '0);
    noData    = (unreadCnt == '0);
    rawFull   = 32'(freeCnt) < 32'(wmThreshold(fullWm));
    rawEmpty  = 32'(unreadCnt) < 32'(wmThreshold(emptyWm));
  end

  wmbuf_flag_pipe #(.LAT(FLAG_LAT), .RST_VAL(1'b0)) u_fullPipe (
    .clk(clk), .rstN(rstN), .d(rawFull), .q(inFull)
  );

  wmbuf_flag_pipe #(.LAT(FLAG_LAT), .RST_VAL(1'b1)) u_emptyPipe (
    .clk(clk), .rstN(rstN), .d(rawEmpty), .q(outEmpty)
  );
endmodule

// File: rtl/wmbuf_status_ctrl.sv
module wmbuf_status_ctrl
  import wmbuf_status_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWr,
  input  logic       hostRd,
  input  logic       noSpace,
  input  logic       noData,
  input  logic       satEvent,
  input  logic       inFull,
  input  logic       outEmpty,
  input  logic       wrIntEn,
  input  logic       rdIntEn,
  input  logic       wrDmaEn,
  input  logic       rdDmaEn,
  input  logic       ovflIntEn,
  input  logic       unflIntEn,
  input  logic       satIntEn,
  output advStrobe_t strb,
  output logic       ovflFlag,
  output logic       unflFlag,
  output logic       satFlag,
  output logic       irq,
  output logic       dmaWrReq,
  output logic       dmaRdReq
);
  always_comb begin
    strb.wrAdv = hostWr && !noSpace;
    strb.rdAdv = hostRd && !noData;
  end

  // Sticky error flags, cleared only by unit reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovflFlag <= 1'b0;
      unflFlag <= 1'b0;
      satFlag  <= 1'b0;
    end else begin
      if (hostWr && noSpace) ovflFlag <= 1'b1;
      if (hostRd && noData)  unflFlag <= 1'b1;
      if (satEvent)          satFlag  <= 1'b1;
    end
  end

  always_comb begin
    dmaWrReq = wrDmaEn && !inFull;
    dmaRdReq = rdDmaEn && !outEmpty;
    irq = (wrIntEn && !inFull) || (rdIntEn && !outEmpty) ||
          (ovflIntEn && ovflFlag) || (unflIntEn && unflFlag) ||
          (satIntEn && satFlag);
  end
endmodule

// File: rtl/wmbuf_status.sv
module wmbuf_status
  import wmbuf_status_pkg::*;
#(
  parameter int  IN_DEPTH  = 16,
  parameter int  OUT_DEPTH = 16,
  parameter int  FLAG_LAT  = 3,
  localparam int IPW = $clog2(IN_DEPTH) + 1,
  localparam int OPW = $clog2(OUT_DEPTH) + 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           hostWr,
  input  logic           hostRd,
  input  logic [IPW-1:0] inTail,
  input  logic [OPW-1:0] outHead,
  input  logic [1:0]     fullWm,
  input  logic [1:0]     emptyWm,
  input  logic           wrIntEn,
  input  logic           rdIntEn,
  input  logic           wrDmaEn,
  input  logic           rdDmaEn,
  input  logic           ovflIntEn,
  input  logic           unflIntEn,
  input  logic           satIntEn,
  input  logic           satEvent,
  output logic           wrAccept,
  output logic           rdAccept,
  output logic [IPW-1:0] wrPtr,
  output logic [OPW-1:0] rdPtr,
  output logic           inFull,
  output logic           outEmpty,
  output logic           ovflFlag,
  output logic           unflFlag,
  output logic           satFlag,
  output logic           irq,
  output logic           dmaWrReq,
  output logic           dmaRdReq
);
  advStrobe_t strb;
  logic       noSpace, noData;

  wmbuf_status_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd),
    .noSpace(noSpace), .noData(noData), .satEvent(satEvent),
    .inFull(inFull), .outEmpty(outEmpty),
    .wrIntEn(wrIntEn), .rdIntEn(rdIntEn), .wrDmaEn(wrDmaEn), .rdDmaEn(rdDmaEn),
    .ovflIntEn(ovflIntEn), .unflIntEn(unflIntEn), .satIntEn(satIntEn),
    .strb(strb), .ovflFlag(ovflFlag), .unflFlag(unflFlag), .satFlag(satFlag),
    .irq(irq), .dmaWrReq(dmaWrReq), .dmaRdReq(dmaRdReq)
  );

  wmbuf_status_dp #(.IN_DEPTH(IN_DEPTH), .OUT_DEPTH(OUT_DEPTH), .FLAG_LAT(FLAG_LAT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inTail(inTail), .outHead(outHead),
    .fullWm(fullWm), .emptyWm(emptyWm), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .noSpace(noSpace), .noData(noData), .inFull(inFull), .outEmpty(outEmpty)
  );

  assign wrAccept = strb.wrAdv;
  assign rdAccept = strb.rdAdv;
endmodule

// File: rtl/wmbuf_status_chk.sv
module wmbuf_status_chk
  import wmbuf_status_pkg::*;
#(
  parameter int  IN_DEPTH  = 16,
  parameter int  OUT_DEPTH = 16,
  localparam int IPW = $clog2(IN_DEPTH) + 1,
  localparam int OPW = $clog2(OUT_DEPTH) + 1
) (
  input logic           clk,
  input logic           rstN,
  input logic           hostWr,
  input logic           hostRd,
  input logic [IPW-1:0] inTail,
  input logic [OPW-1:0] outHead,
  input logic [1:0]     fullWm,
  input logic [1:0]     emptyWm,
  input logic           wrIntEn,
  input logic           rdIntEn,
  input logic           wrDmaEn,
  input logic           rdDmaEn,
  input logic           satIntEn,
  input logic           satEvent,
  input logic           wrAccept,
  input logic           rdAccept,
  input logic [IPW-1:0] wrPtr,
  input logic [OPW-1:0] rdPtr,
  input logic           inFull,
  input logic           outEmpty,
  input logic           ovflFlag,
  input logic           unflFlag,
  input logic           satFlag,
  input logic           irq,
  input logic           dmaWrReq,
  input logic           dmaRdReq
);
  logic [1:0]     sinceRst;
  logic [IPW-1:0] freeNow;
  logic [OPW-1:0] unreadNow;
  logic           fullCond, emptyCond;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  always_comb begin
    freeNow   = IPW'(IN_DEPTH) - (wrPtr - inTail);
    unreadNow = outHead - rdPtr;
    fullCond  = 32'(freeNow) < 32'(wmThreshold(fullWm));
    emptyCond = 32'(unreadNow) < 32'(wmThreshold(emptyWm));
  end

  p_full_latency_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (inFull == $past(fullCond, 3)));

  p_empty_latency_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (outEmpty == $past(emptyCond, 3)));

  p_wr_advance_r11: assert property (@(posedge clk) disable iff (!rstN)
    wrAccept |=> (wrPtr == $past(wrPtr) + 1'b1));

  p_rd_advance_r11: assert property (@(posedge clk) disable iff (!rstN)
    rdAccept |=> (rdPtr == $past(rdPtr) + 1'b1));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && !wrAccept) |=> (ovflFlag && $stable(wrPtr)));

  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && !rdAccept) |=> (unflFlag && $stable(rdPtr)));

  p_ovfl_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    ovflFlag |=> ovflFlag);

  p_unfl_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    unflFlag |=> unflFlag);

  p_sat_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (satEvent || satFlag) |=> satFlag);

  p_dma_wr_r9: assert property (@(posedge clk) disable iff (!rstN)
    dmaWrReq |-> (wrDmaEn && !inFull));

  p_dma_rd_r9: assert property (@(posedge clk) disable iff (!rstN)
    dmaRdReq |-> (rdDmaEn && !outEmpty));

  p_irq_sources_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((satIntEn && satFlag) || (wrIntEn && !inFull) || (rdIntEn && !outEmpty)) |-> irq);
endmodule

bind wmbuf_status wmbuf_status_chk #(.IN_DEPTH(IN_DEPTH), .OUT_DEPTH(OUT_DEPTH)) u_chk (.*);

// File: tb/wmbuf_status_tb.sv
module wmbuf_status_tb;
  localparam int D = 16;
  localparam int PW = $clog2(D) + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWr = 0, hostRd = 0, satEvent = 0;
  logic [PW-1:0] inTail = '0, outHead = '0;
  logic [1:0] fullWm = 2'd1, emptyWm = 2'd0;
  logic wrIntEn = 0, rdIntEn = 0, wrDmaEn = 0, rdDmaEn = 0;
  logic ovflIntEn = 0, unflIntEn = 0, satIntEn = 0;
  logic wrAccept, rdAccept, inFull, outEmpty, ovflFlag, unflFlag, satFlag;
  logic irq, dmaWrReq, dmaRdReq;
  logic [PW-1:0] wrPtr, rdPtr;

  int checks = 0;
  int errors = 0;
  logic lastAcc;

  always #10 clk = ~clk;

  wmbuf_status #(.IN_DEPTH(D), .OUT_DEPTH(D)) u_dut (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd),
    .inTail(inTail), .outHead(outHead), .fullWm(fullWm), .emptyWm(emptyWm),
    .wrIntEn(wrIntEn), .rdIntEn(rdIntEn), .wrDmaEn(wrDmaEn), .rdDmaEn(rdDmaEn),
    .ovflIntEn(ovflIntEn), .unflIntEn(unflIntEn), .satIntEn(satIntEn),
    .satEvent(satEvent), .wrAccept(wrAccept), .rdAccept(rdAccept),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .inFull(inFull), .outEmpty(outEmpty),
    .ovflFlag(ovflFlag), .unflFlag(unflFlag), .satFlag(satFlag),
    .irq(irq), .dmaWrReq(dmaWrReq), .dmaRdReq(dmaRdReq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One write: returns at the negedge after the sampling edge
  task automatic hostWrite();
    @(negedge clk);
    hostWr = 1'b1;
    #1 lastAcc = wrAccept;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic hostRead();
    @(negedge clk);
    hostRd = 1'b1;
    #1 lastAcc = rdAccept;
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic testReset();
    check("R1 wrPtr", int'(wrPtr), 0);
    check("R1 rdPtr", int'(rdPtr), 0);
    check("R1 inFull", int'(inFull), 0);
    check("R1 outEmpty", int'(outEmpty), 1);
    check("R1 sticky", int'({ovflFlag, unflFlag, satFlag}), 0);
    check("R1 irq/dma", int'({irq, dmaWrReq, dmaRdReq}), 0);
  endtask

  task automatic testFillLatency();
    fullWm = 2'd1;  // threshold 2
    for (int i = 0; i < 14; i++) hostWrite();
    idle(3);
    check("R3 free=2 thr=2 not full", int'(inFull), 0);
    hostWrite();  // free becomes 1
    check("R2 wrPtr after 15", int'(wrPtr), 15);
    check("R5 edge k", int'(inFull), 0);
    idle(1);
    check("R5 edge k+1", int'(inFull), 0);
    idle(1);
    check("R5 edge k+2", int'(inFull), 0);
    idle(1);
    check("R5 edge k+3", int'(inFull), 1);
  endtask

  task automatic testOverflow();
    hostWrite();  // last free slot
    check("R11 last slot accepted", int'(lastAcc), 1);
    check("R11 wrPtr 16", int'(wrPtr), 16);
    hostWrite();  // no space
    check("R6 wrAccept low", int'(lastAcc), 0);
    check("R6 wrPtr held", int'(wrPtr), 16);
    check("R6 ovfl set", int'(ovflFlag), 1);
    wrDmaEn = 1'b1;
    ovflIntEn = 1'b1;
    #1;
    check("R9 no write dma while full", int'(dmaWrReq), 0);
    check("R10 irq from overflow", int'(irq), 1);
    ovflIntEn = 1'b0;
    #1;
    check("R10 overflow masked", int'(irq), 0);
    inTail = 5'd16;  // consumer frees whole ring
    idle(4);
    check("R2 freed ring not full", int'(inFull), 0);
    check("R6 ovfl sticky", int'(ovflFlag), 1);
    check("R9 write dma", int'(dmaWrReq), 1);
    wrIntEn = 1'b1;
    #1;
    check("R10 irq not full", int'(irq), 1);
    wrIntEn = 1'b0;
    wrDmaEn = 1'b0;
  endtask

  task automatic testFullThreshold8();
    fullWm = 2'd3;  // threshold 8
    for (int i = 0; i < 8; i++) hostWrite();
    idle(4);
    check("R3 free=8 thr=8", int'(inFull), 0);
    hostWrite();
    idle(4);
    check("R3 free=7 thr=8", int'(inFull), 1);
    check("R2 wrPtr 25", int'(wrPtr), 25);
  endtask

  task automatic testOutput();
    rdDmaEn = 1'b1;
    #1;
    check("R9 no read dma while empty", int'(dmaRdReq), 0);
    hostRead();
    check("R7 rdAccept low", int'(lastAcc), 0);
    check("R7 rdPtr held", int'(rdPtr), 0);
    check("R7 unfl set", int'(unflFlag), 1);
    emptyWm = 2'd2;  // threshold 4
    outHead = 5'd3;
    idle(4);
    check("R4 unread=3 thr=4", int'(outEmpty), 1);
    outHead = 5'd4;
    idle(4);
    check("R4 unread=4 thr=4", int'(outEmpty), 0);
    check("R9 read dma", int'(dmaRdReq), 1);
    rdIntEn = 1'b1;
    #1;
    check("R10 irq not empty", int'(irq), 1);
    rdIntEn = 1'b0;
    emptyWm = 2'd0;  // threshold 1
    for (int i = 0; i < 3; i++) hostRead();
    idle(3);
    check("R11 rdPtr 3", int'(rdPtr), 3);
    check("R4 unread=1 thr=1", int'(outEmpty), 0);
    hostRead();
    check("R5 empty edge k", int'(outEmpty), 0);
    idle(2);
    check("R5 empty edge k+2", int'(outEmpty), 0);
    idle(1);
    check("R5 empty edge k+3", int'(outEmpty), 1);
    hostRead();
    check("R7 drained read refused", int'(lastAcc), 0);
    check("R7 rdPtr stays 4", int'(rdPtr), 4);
    check("R7 unfl sticky", int'(unflFlag), 1);
    unflIntEn = 1'b1;
    #1;
    check("R10 irq from underflow", int'(irq), 1);
    unflIntEn = 1'b0;
    rdDmaEn = 1'b0;
  endtask

  task automatic testSaturation();
    satIntEn = 1'b1;
    #1;
    check("R8 sat clear before", int'(satFlag), 0);
    check("R10 sat enable alone", int'(irq), 0);
    @(negedge clk);
    satEvent = 1'b1;
    @(negedge clk);
    satEvent = 1'b0;
    check("R8 sat set", int'(satFlag), 1);
    check("R10 irq from sat", int'(irq), 1);
    idle(5);
    check("R8 sat sticky", int'(satFlag), 1);
    satIntEn = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    testReset();
    rstN = 1'b1;
    idle(2);
    testReset();
    testFillLatency();
    testOverflow();
    testFullThreshold8();
    testOutput();
    testSaturation();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule